// File: doc/BRIEF.md
# Transparent Character-Framed Block Framer

This block builds and parses byte-oriented synchronous blocks that carry arbitrary binary payloads. On the transmit side a single byte stream delivers an optional header followed by payload bytes. The block wraps them in a character-delimited block: a run of sync characters, a start-of-header character with the header bytes, an escaped start-of-text pair, the payload with every escape character doubled, an escaped end delimiter, and a two-byte CRC-16. Each output byte is handed to a character-rate serializer through a valid/ready pair.

The receive side accepts one line byte per strobe. It hunts for a run of sync characters, follows the delimiters and removes the escape doubling. It returns header and payload bytes as they arrive, each tagged with its kind. When the block ends it raises a one-cycle done pulse with three status bits: CRC mismatch, format violation, and whether the block was the last of a message (ETX) or one of several (ETB). Bytes are emitted as soon as they are decoded, so a consumer that needs whole-block integrity holds them until the done pulse.

All character codes, the sync run length and the CRC polynomial are parameters. Defaults: SYN 0x32, SOH 0x01, STX 0x02, ETB 0x26, ETX 0x03, DLE 0x10, two sync characters.

Top module: `sync_block_framer`

## Requirements
- R1: After reset, or after a block completes, the first valid input byte starts a block whose first SYN_COUNT line bytes (default 2) are the SYN code 0x32.
- R2: If the first input byte of a block is flagged as header (in_hdr_i=1), the sync run is followed by SOH 0x01 and then the header bytes unchanged. If it is not flagged, no SOH is sent.
- R3: The payload is opened by the pair DLE 0x10, STX 0x02. It is closed by DLE followed by ETX 0x03 when in_final_i was 1 with the last payload byte, or by ETB 0x26 otherwise.
- R4: A payload byte equal to DLE 0x10 is sent twice in a row. Every other payload byte, including SYN, STX, ETB and ETX values, is sent once and unchanged.
- R5: The trailer is a CRC-16 with polynomial x^16+x^15+x^2+1, zero preset, data and result bit-reflected (least significant bit first). It covers the unescaped payload bytes and the closing ETB/ETX byte, but not the escape DLEs, SOH, header or SYN bytes. The low CRC byte is sent first, then the high byte.
- R6: The receiver leaves its hunt state only on SOH or DLE arriving directly after at least SYN_COUNT consecutive SYN bytes. Any other line bytes produce no data output and no done pulse.
- R7: The receiver outputs header bytes with rx_hdr_o=1 and payload bytes with rx_hdr_o=0. A DLE DLE pair yields one DLE data byte, and SYN bytes inside the text are passed as data.
- R8: One cycle after the second CRC byte is accepted, rx_done_o pulses for one cycle. With it, rx_etx_o is 1 for an ETX end and 0 for an ETB end, and rx_crc_err_o is 1 exactly when the received CRC differs from the computed one.
- R9: A DLE inside the text followed by a byte other than DLE, ETB or ETX, or a byte other than STX after the opening DLE, ends the block. The done pulse then carries rx_fmt_err_o=1 and rx_crc_err_o=0, and the receiver returns to hunting, so the next well-formed block decodes.
- R10: Input bytes are consumed only on a cycle in which a line byte is transferred (tx_valid_o and tx_ready_i high). While tx_ready_i is low, the framer state does not advance.
- R11: While rst_ni is low, tx_valid_o, in_ready_o, rx_data_valid_o, rx_done_o and all receive status bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Transmit input byte valid |
| in_data_i | input | DATA_W | Transmit input byte |
| in_hdr_i | input | 1 | Input byte belongs to the header |
| in_last_i | input | 1 | Input byte is the last payload byte |
| in_final_i | input | 1 | With the last byte: close with ETX (1) or ETB (0) |
| in_ready_o | output | 1 | Input byte consumed this cycle |
| tx_valid_o | output | 1 | Line byte valid |
| tx_byte_o | output | DATA_W | Line byte to the serializer |
| tx_ready_i | input | 1 | Serializer takes the line byte |
| rx_valid_i | input | 1 | Received line byte strobe |
| rx_byte_i | input | DATA_W | Received line byte |
| rx_data_valid_o | output | 1 | Decoded byte valid |
| rx_data_o | output | DATA_W | Decoded header or payload byte |
| rx_hdr_o | output | 1 | Decoded byte is a header byte |
| rx_done_o | output | 1 | Block ended, status valid |
| rx_etx_o | output | 1 | Block ended with ETX |
| rx_crc_err_o | output | 1 | CRC mismatch |
| rx_fmt_err_o | output | 1 | Escape or delimiter violation |

## Verification
The bench builds the block with its default parameters: 8-bit bytes, the default character codes, a two-SYN sync run and the reflected 0x8005 polynomial. With 8-bit bytes, payload values equal to every control code can be sent, so doubled DLEs and SYN pairs inside the text are exercised directly. The two-SYN threshold lets a one-SYN lead-in and a three-SYN lead-in test the hunt logic. Line images are compared against an independently computed encoding and then fed back into the receiver, with serializer stalls and line gaps.

// File: rtl/sbf_pkg.sv
package sbf_pkg;

  typedef enum logic [3:0] {
    TX_IDLE, TX_SYN, TX_SOH, TX_HDR, TX_DLE_O, TX_STX,
    TX_DATA, TX_DUP, TX_DLE_C, TX_TERM, TX_CRC_LO, TX_CRC_HI
  } tx_st_e;

  typedef enum logic [2:0] {
    RX_HUNT, RX_HDR, RX_OPEN, RX_TEXT, RX_ESC, RX_CRC_LO, RX_CRC_HI
  } rx_st_e;

endpackage

// File: rtl/sbf_crc16.sv
module sbf_crc16 #(
  parameter int DATA_W = 8,
  parameter int CRC_W  = 16,
  parameter logic [CRC_W-1:0] POLY_R = 16'hA001
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              upd_i,
  input  logic [DATA_W-1:0] byte_i,
  output logic [CRC_W-1:0]  crc_o
);

  logic [CRC_W-1:0] crc_q;
  logic [DATA_W:0][CRC_W-1:0] stage;

  assign stage[0] = crc_q;

  // one reflected shift step per input bit, lsb first
  for (genvar gi = 0; gi < DATA_W; gi++) begin : g_step
    assign stage[gi+1] = (stage[gi][0] ^ byte_i[gi]) ?
                         ((stage[gi] >> 1) ^ POLY_R) : (stage[gi] >> 1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    crc_q <= '0;
    else if (clr_i) crc_q <= '0;
    else if (upd_i) crc_q <= stage[DATA_W];
  end

  assign crc_o = crc_q;

endmodule

// File: rtl/sbf_tx.sv
module sbf_tx
  import sbf_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int CRC_W     = 16,
  parameter int SYN_COUNT = 2,
  parameter logic [DATA_W-1:0] SYN_CODE = 8'h32,
  parameter logic [DATA_W-1:0] SOH_CODE = 8'h01,
  parameter logic [DATA_W-1:0] STX_CODE = 8'h02,
  parameter logic [DATA_W-1:0] ETB_CODE = 8'h26,
  parameter logic [DATA_W-1:0] ETX_CODE = 8'h03,
  parameter logic [DATA_W-1:0] DLE_CODE = 8'h10,
  parameter logic [CRC_W-1:0]  POLY_R   = 16'hA001
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  input  logic [DATA_W-1:0] in_data_i,
  input  logic              in_hdr_i,
  input  logic              in_last_i,
  input  logic              in_final_i,
  output logic              in_ready_o,
  output logic              tx_valid_o,
  output logic [DATA_W-1:0] tx_byte_o,
  input  logic              tx_ready_i
);

  localparam int CW = $clog2(SYN_COUNT + 1);

  tx_st_e st_q, st_d;
  logic [CW-1:0] syn_cnt_q;
  logic hdr_q, fin_q;
  logic fire;
  logic crc_clr, crc_upd;
  logic [DATA_W-1:0] crc_byte, term_code;
  logic [CRC_W-1:0] crc;

  assign fire      = tx_valid_o & tx_ready_i;
  assign term_code = fin_q ? ETX_CODE : ETB_CODE;

  sbf_crc16 #(.DATA_W(DATA_W), .CRC_W(CRC_W), .POLY_R(POLY_R)) u_crc (
    .clk_i, .rst_ni, .clr_i(crc_clr), .upd_i(crc_upd), .byte_i(crc_byte), .crc_o(crc)
  );

  always_comb begin
    st_d       = st_q;
    tx_valid_o = 1'b0;
    tx_byte_o  = SYN_CODE;
    in_ready_o = 1'b0;
    crc_clr    = 1'b0;
    crc_upd    = 1'b0;
    crc_byte   = in_data_i;
    case (st_q)
      TX_IDLE: if (in_valid_i) st_d = TX_SYN;
      TX_SYN: begin
        tx_valid_o = 1'b1;
        if (fire && syn_cnt_q == CW'(SYN_COUNT - 1)) st_d = hdr_q ? TX_SOH : TX_DLE_O;
      end
      TX_SOH: begin
        tx_valid_o = 1'b1;
        tx_byte_o  = SOH_CODE;
        if (fire) st_d = TX_HDR;
      end
      TX_HDR: begin
        // first payload byte closes the header with the escape of DLE STX
        tx_valid_o = in_valid_i;
        tx_byte_o  = in_hdr_i ? in_data_i : DLE_CODE;
        if (fire) begin
          if (in_hdr_i) in_ready_o = 1'b1;
          else          st_d = TX_STX;
        end
      end
      TX_DLE_O: begin
        tx_valid_o = 1'b1;
        tx_byte_o  = DLE_CODE;
        if (fire) st_d = TX_STX;
      end
      TX_STX: begin
        tx_valid_o = 1'b1;
        tx_byte_o  = STX_CODE;
        if (fire) begin
          crc_clr = 1'b1;
          st_d    = TX_DATA;
        end
      end
      TX_DATA: begin
        tx_valid_o = in_valid_i;
        tx_byte_o  = in_data_i;
        if (fire) begin
          if (in_data_i == DLE_CODE) st_d = TX_DUP;
          else begin
            in_ready_o = 1'b1;
            crc_upd    = 1'b1;
            if (in_last_i) st_d = TX_DLE_C;
          end
        end
      end
      TX_DUP: begin
        tx_valid_o = in_valid_i;
        tx_byte_o  = DLE_CODE;
        if (fire) begin
          in_ready_o = 1'b1;
          crc_upd    = 1'b1;
          st_d       = in_last_i ? TX_DLE_C : TX_DATA;
        end
      end
      TX_DLE_C: begin
        tx_valid_o = 1'b1;
        tx_byte_o  = DLE_CODE;
        if (fire) st_d = TX_TERM;
      end
      TX_TERM: begin
        tx_valid_o = 1'b1;
        tx_byte_o  = term_code;
        crc_byte   = term_code;
        if (fire) begin
          crc_upd = 1'b1;
          st_d    = TX_CRC_LO;
        end
      end
      TX_CRC_LO: begin
        tx_valid_o = 1'b1;
        tx_byte_o  = crc[DATA_W-1:0];
        if (fire) st_d = TX_CRC_HI;
      end
      TX_CRC_HI: begin
        tx_valid_o = 1'b1;
        tx_byte_o  = crc[CRC_W-1:DATA_W];
        if (fire) st_d = TX_IDLE;
      end
      default: st_d = TX_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= TX_IDLE;
      syn_cnt_q <= '0;
      hdr_q     <= 1'b0;
      fin_q     <= 1'b0;
    end else begin
      st_q <= st_d;
      if (st_q == TX_SYN) begin
        if (fire) syn_cnt_q <= syn_cnt_q + 1'b1;
      end else begin
        syn_cnt_q <= '0;
      end
      if (st_q == TX_IDLE && in_valid_i) hdr_q <= in_hdr_i;
      if (in_ready_o && in_last_i && !in_hdr_i) fin_q <= in_final_i;
    end
  end

  assert_syn_start_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == TX_IDLE && in_valid_i) |=> (tx_valid_o && tx_byte_o == SYN_CODE));

  assert_dle_dup_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == TX_DATA && fire && tx_byte_o == DLE_CODE) |=> (st_q == TX_DUP && tx_byte_o == DLE_CODE));

  assert_crc_pair_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == TX_CRC_LO && fire) |=> (st_q == TX_CRC_HI));

  assert_stall_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_o && !tx_ready_i) |=> $stable(st_q));

endmodule

// File: rtl/sbf_rx.sv
module sbf_rx
  import sbf_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int CRC_W     = 16,
  parameter int SYN_COUNT = 2,
  parameter logic [DATA_W-1:0] SYN_CODE = 8'h32,
  parameter logic [DATA_W-1:0] SOH_CODE = 8'h01,
  parameter logic [DATA_W-1:0] STX_CODE = 8'h02,
  parameter logic [DATA_W-1:0] ETB_CODE = 8'h26,
  parameter logic [DATA_W-1:0] ETX_CODE = 8'h03,
  parameter logic [DATA_W-1:0] DLE_CODE = 8'h10,
  parameter logic [CRC_W-1:0]  POLY_R   = 16'hA001
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_valid_i,
  input  logic [DATA_W-1:0] rx_byte_i,
  output logic              rx_data_valid_o,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              rx_hdr_o,
  output logic              rx_done_o,
  output logic              rx_etx_o,
  output logic              rx_crc_err_o,
  output logic              rx_fmt_err_o
);

  localparam int CW = $clog2(SYN_COUNT + 1);

  rx_st_e st_q;
  logic [CW-1:0] syn_cnt_q;
  logic [DATA_W-1:0] lo_q;
  logic etx_pend_q;
  logic crc_clr, crc_upd, is_term;
  logic [CRC_W-1:0] crc;

  assign is_term = (rx_byte_i == ETB_CODE) || (rx_byte_i == ETX_CODE);

  always_comb begin
    crc_clr = rx_valid_i && st_q == RX_OPEN && rx_byte_i == STX_CODE;
    crc_upd = rx_valid_i && ((st_q == RX_TEXT && rx_byte_i != DLE_CODE) ||
                             (st_q == RX_ESC && (rx_byte_i == DLE_CODE || is_term)));
  end

  sbf_crc16 #(.DATA_W(DATA_W), .CRC_W(CRC_W), .POLY_R(POLY_R)) u_crc (
    .clk_i, .rst_ni, .clr_i(crc_clr), .upd_i(crc_upd), .byte_i(rx_byte_i), .crc_o(crc)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q            <= RX_HUNT;
      syn_cnt_q       <= '0;
      lo_q            <= '0;
      etx_pend_q      <= 1'b0;
      rx_data_valid_o <= 1'b0;
      rx_data_o       <= '0;
      rx_hdr_o        <= 1'b0;
      rx_done_o       <= 1'b0;
      rx_etx_o        <= 1'b0;
      rx_crc_err_o    <= 1'b0;
      rx_fmt_err_o    <= 1'b0;
    end else begin
      rx_data_valid_o <= 1'b0;
      rx_done_o       <= 1'b0;
      if (rx_valid_i) begin
        case (st_q)
          RX_HUNT: begin
            if (rx_byte_i == SYN_CODE) begin
              if (syn_cnt_q != CW'(SYN_COUNT)) syn_cnt_q <= syn_cnt_q + 1'b1;
            end else if (syn_cnt_q == CW'(SYN_COUNT) && rx_byte_i == SOH_CODE) begin
              st_q      <= RX_HDR;
              syn_cnt_q <= '0;
            end else if (syn_cnt_q == CW'(SYN_COUNT) && rx_byte_i == DLE_CODE) begin
              st_q      <= RX_OPEN;
              syn_cnt_q <= '0;
            end else begin
              syn_cnt_q <= '0;
            end
          end
          RX_HDR: begin
            if (rx_byte_i == DLE_CODE) st_q <= RX_OPEN;
            else begin
              rx_data_valid_o <= 1'b1;
              rx_data_o       <= rx_byte_i;
              rx_hdr_o        <= 1'b1;
            end
          end
          RX_OPEN: begin
            if (rx_byte_i == STX_CODE) st_q <= RX_TEXT;
            else begin
              rx_done_o    <= 1'b1;
              rx_fmt_err_o <= 1'b1;
              rx_crc_err_o <= 1'b0;
              rx_etx_o     <= 1'b0;
              st_q         <= RX_HUNT;
            end
          end
          RX_TEXT: begin
            if (rx_byte_i == DLE_CODE) st_q <= RX_ESC;
            else begin
              rx_data_valid_o <= 1'b1;
              rx_data_o       <= rx_byte_i;
              rx_hdr_o        <= 1'b0;
            end
          end
          RX_ESC: begin
            if (rx_byte_i == DLE_CODE) begin
              rx_data_valid_o <= 1'b1;
              rx_data_o       <= rx_byte_i;
              rx_hdr_o        <= 1'b0;
              st_q            <= RX_TEXT;
            end else if (is_term) begin
              etx_pend_q <= (rx_byte_i == ETX_CODE);
              st_q       <= RX_CRC_LO;
            end else begin
              rx_done_o    <= 1'b1;
              rx_fmt_err_o <= 1'b1;
              rx_crc_err_o <= 1'b0;
              rx_etx_o     <= 1'b0;
              st_q         <= RX_HUNT;
            end
          end
          RX_CRC_LO: begin
            lo_q <= rx_byte_i;
            st_q <= RX_CRC_HI;
          end
          RX_CRC_HI: begin
            rx_done_o    <= 1'b1;
            rx_fmt_err_o <= 1'b0;
            rx_crc_err_o <= ({rx_byte_i, lo_q} != crc);
            rx_etx_o     <= etx_pend_q;
            st_q         <= RX_HUNT;
          end
          default: st_q <= RX_HUNT;
        endcase
      end
    end
  end

  assert_hunt_silent_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_data_valid_o |-> $past(st_q != RX_HUNT));

  assert_done_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_done_o |=> !rx_done_o);

  assert_done_rehunt_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_done_o |-> (st_q == RX_HUNT));

  assert_err_exclusive_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_done_o |-> !(rx_crc_err_o && rx_fmt_err_o));

endmodule

// File: rtl/sync_block_framer.sv
module sync_block_framer #(
  parameter int DATA_W    = 8,
  parameter int SYN_COUNT = 2,
  parameter logic [DATA_W-1:0] SYN_CODE = 8'h32,
  parameter logic [DATA_W-1:0] SOH_CODE = 8'h01,
  parameter logic [DATA_W-1:0] STX_CODE = 8'h02,
  parameter logic [DATA_W-1:0] ETB_CODE = 8'h26,
  parameter logic [DATA_W-1:0] ETX_CODE = 8'h03,
  parameter logic [DATA_W-1:0] DLE_CODE = 8'h10,
  parameter logic [2*DATA_W-1:0] CRC_POLY_R = 16'hA001
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  input  logic [DATA_W-1:0] in_data_i,
  input  logic              in_hdr_i,
  input  logic              in_last_i,
  input  logic              in_final_i,
  output logic              in_ready_o,
  output logic              tx_valid_o,
  output logic [DATA_W-1:0] tx_byte_o,
  input  logic              tx_ready_i,
  input  logic              rx_valid_i,
  input  logic [DATA_W-1:0] rx_byte_i,
  output logic              rx_data_valid_o,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              rx_hdr_o,
  output logic              rx_done_o,
  output logic              rx_etx_o,
  output logic              rx_crc_err_o,
  output logic              rx_fmt_err_o
);

  localparam int CRC_W = 2 * DATA_W;

  sbf_tx #(
    .DATA_W(DATA_W), .CRC_W(CRC_W), .SYN_COUNT(SYN_COUNT),
    .SYN_CODE(SYN_CODE), .SOH_CODE(SOH_CODE), .STX_CODE(STX_CODE),
    .ETB_CODE(ETB_CODE), .ETX_CODE(ETX_CODE), .DLE_CODE(DLE_CODE), .POLY_R(CRC_POLY_R)
  ) u_tx (
    .clk_i, .rst_ni, .in_valid_i, .in_data_i, .in_hdr_i, .in_last_i, .in_final_i,
    .in_ready_o, .tx_valid_o, .tx_byte_o, .tx_ready_i
  );

  sbf_rx #(
    .DATA_W(DATA_W), .CRC_W(CRC_W), .SYN_COUNT(SYN_COUNT),
    .SYN_CODE(SYN_CODE), .SOH_CODE(SOH_CODE), .STX_CODE(STX_CODE),
    .ETB_CODE(ETB_CODE), .ETX_CODE(ETX_CODE), .DLE_CODE(DLE_CODE), .POLY_R(CRC_POLY_R)
  ) u_rx (
    .clk_i, .rst_ni, .rx_valid_i, .rx_byte_i, .rx_data_valid_o, .rx_data_o, .rx_hdr_o,
    .rx_done_o, .rx_etx_o, .rx_crc_err_o, .rx_fmt_err_o
  );

endmodule

// File: tb/sync_block_framer_bench.sv
module sync_block_framer_bench;

  localparam int CLK_PERIOD = 10;
  localparam int SYN_N = 2;

  typedef logic [7:0] byte_q_t [$];
  typedef struct packed {
    logic [1:0]  nh;
    logic [2:0]  np;
    logic        fin;
    logic [15:0] hdr;
    logic [31:0] pay;
  } vec_t;

  localparam int NVEC = 6;
  localparam vec_t VECS [NVEC] = '{
    '{2'd2, 3'd3, 1'b1, 16'hC105, 32'h41424300},
    '{2'd0, 3'd4, 1'b0, 16'h0000, 32'h10551010},
    '{2'd1, 3'd4, 1'b1, 16'h7E00, 32'h32320203},
    '{2'd2, 3'd1, 1'b0, 16'h3226, 32'h26000000},
    '{2'd0, 3'd1, 1'b1, 16'h0000, 32'h10000000},
    '{2'd1, 3'd2, 1'b1, 16'h0000, 32'hFF000000}
  };

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic in_valid_i = 1'b0, in_hdr_i = 1'b0, in_last_i = 1'b0, in_final_i = 1'b0;
  logic [7:0] in_data_i = '0;
  logic in_ready_o, tx_valid_o;
  logic [7:0] tx_byte_o;
  logic tx_ready_i = 1'b0;
  logic rx_valid_i = 1'b0;
  logic [7:0] rx_byte_i = '0;
  logic rx_data_valid_o, rx_hdr_o, rx_done_o, rx_etx_o, rx_crc_err_o, rx_fmt_err_o;
  logic [7:0] rx_data_o;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  byte_q_t exp_line, tx_got;
  string exp_tag [$];
  logic [8:0] rx_got [$];
  logic [8:0] rx_exp [$];
  int done_cnt = 0;
  logic last_etx, last_crc, last_fmt;

  sync_block_framer u_sync_block_framer (
    .clk_i(clk), .rst_ni, .in_valid_i, .in_data_i, .in_hdr_i, .in_last_i, .in_final_i,
    .in_ready_o, .tx_valid_o, .tx_byte_o, .tx_ready_i, .rx_valid_i, .rx_byte_i,
    .rx_data_valid_o, .rx_data_o, .rx_hdr_o, .rx_done_o, .rx_etx_o, .rx_crc_err_o, .rx_fmt_err_o
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    if (rst_ni) begin
      if (rx_data_valid_o) rx_got.push_back({rx_hdr_o, rx_data_o});
      if (rx_done_o) begin
        done_cnt++;
        last_etx = rx_etx_o;
        last_crc = rx_crc_err_o;
        last_fmt = rx_fmt_err_o;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] rev8(input logic [7:0] b);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = b[7-i];
    return r;
  endfunction

  // msb-first register on bit-reversed bytes, result reversed
  function automatic logic [15:0] crc_model(input byte_q_t q);
    logic [15:0] c = 16'h0000;
    logic [15:0] r;
    foreach (q[i]) begin
      c = c ^ {rev8(q[i]), 8'h00};
      for (int b = 0; b < 8; b++) c = c[15] ? ((c << 1) ^ 16'h8005) : (c << 1);
    end
    for (int i = 0; i < 16; i++) r[i] = c[15-i];
    return r;
  endfunction

  function automatic logic [7:0] vbyte(input vec_t v, input int k);
    if (k < int'(v.nh)) return v.hdr[15-8*k -: 8];
    return v.pay[31-8*(k-int'(v.nh)) -: 8];
  endfunction

  task automatic build_line(input vec_t v);
    byte_q_t pl;
    logic [15:0] c;
    logic [7:0] b, term;
    exp_line.delete(); exp_tag.delete(); rx_exp.delete();
    for (int i = 0; i < SYN_N; i++) begin exp_line.push_back(8'h32); exp_tag.push_back("R1 sync run"); end
    if (v.nh != 0) begin
      exp_line.push_back(8'h01); exp_tag.push_back("R2 header start");
      for (int k = 0; k < int'(v.nh); k++) begin
        exp_line.push_back(vbyte(v, k)); exp_tag.push_back("R2 header byte");
        rx_exp.push_back({1'b1, vbyte(v, k)});
      end
    end
    exp_line.push_back(8'h10); exp_tag.push_back("R3 open escape");
    exp_line.push_back(8'h02); exp_tag.push_back("R3 open STX");
    for (int k = int'(v.nh); k < int'(v.nh) + int'(v.np); k++) begin
      b = vbyte(v, k);
      if (b == 8'h10) begin exp_line.push_back(8'h10); exp_tag.push_back("R4 doubled DLE"); end
      exp_line.push_back(b); exp_tag.push_back("R4 payload byte");
      pl.push_back(b);
      rx_exp.push_back({1'b0, b});
    end
    term = v.fin ? 8'h03 : 8'h26;
    exp_line.push_back(8'h10); exp_tag.push_back("R3 close escape");
    exp_line.push_back(term); exp_tag.push_back("R3 close ETB/ETX");
    pl.push_back(term);
    c = crc_model(pl);
    exp_line.push_back(c[7:0]); exp_tag.push_back("R5 crc low");
    exp_line.push_back(c[15:8]); exp_tag.push_back("R5 crc high");
  endtask

  task automatic send_tx(input vec_t v, input bit stall);
    int k = 0;
    int total = int'(v.nh) + int'(v.np);
    int bp_bad = 0;
    bit fire_in;
    tx_got.delete();
    for (int cyc = 0; cyc < 400 && tx_got.size() < exp_line.size(); cyc++) begin
      @(negedge clk);
      tx_ready_i = !(stall && (cyc % 3 == 2));
      if (k < total) begin
        in_valid_i = 1'b1;
        in_data_i  = vbyte(v, k);
        in_hdr_i   = (k < int'(v.nh));
        in_last_i  = (k == total - 1);
        in_final_i = v.fin;
      end else begin
        in_valid_i = 1'b0;
      end
      #1;
      if (!tx_ready_i && in_ready_o) bp_bad++;
      fire_in = in_valid_i && in_ready_o;
      if (tx_valid_o && tx_ready_i) tx_got.push_back(tx_byte_o);
      @(posedge clk);
      if (fire_in) k++;
    end
    @(negedge clk);
    in_valid_i = 1'b0; tx_ready_i = 1'b1;
    #1;
    chk(bp_bad == 0, "R10 no consume while stalled", bp_bad, 0);
    chk(k == total, "R10 all input consumed", k, total);
    chk(tx_valid_o == 1'b0, "R3 framer idle after trailer", tx_valid_o, 0);
    tx_ready_i = 1'b0;
  endtask

  task automatic feed_rx(input byte_q_t q, input bit gaps);
    rx_got.delete();
    done_cnt = 0;
    foreach (q[i]) begin
      if (gaps && (i % 4 == 3)) begin @(negedge clk); rx_valid_i = 1'b0; end
      @(negedge clk);
      rx_valid_i = 1'b1;
      rx_byte_i  = q[i];
    end
    @(negedge clk);
    rx_valid_i = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic check_rx_data(input string tag);
    chk(rx_got.size() == rx_exp.size(), {tag, " decoded count"}, rx_got.size(), rx_exp.size());
    foreach (rx_exp[i]) begin
      if (i < rx_got.size()) chk(rx_got[i] == rx_exp[i], {tag, " decoded byte"}, rx_got[i], rx_exp[i]);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    byte_q_t q;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(tx_valid_o == 0 && in_ready_o == 0, "R11 tx outputs in reset", {tx_valid_o, in_ready_o}, 0);
    chk({rx_data_valid_o, rx_done_o, rx_etx_o, rx_crc_err_o, rx_fmt_err_o} == 5'b0,
        "R11 rx outputs in reset", {rx_data_valid_o, rx_done_o, rx_etx_o, rx_crc_err_o, rx_fmt_err_o}, 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);

    for (int vi = 0; vi < NVEC; vi++) begin
      build_line(VECS[vi]);
      send_tx(VECS[vi], vi[0]);
      chk(tx_got.size() == exp_line.size(), "R3 line length", tx_got.size(), exp_line.size());
      foreach (exp_line[i]) begin
        if (i < tx_got.size()) chk(tx_got[i] == exp_line[i], exp_tag[i], tx_got[i], exp_line[i]);
      end
      feed_rx(exp_line, vi[0]);
      check_rx_data("R7");
      chk(done_cnt == 1, "R8 one done pulse", done_cnt, 1);
      chk(last_crc == 0 && last_fmt == 0, "R8 clean status", {last_crc, last_fmt}, 0);
      chk(last_etx == VECS[vi].fin, "R8 ETX/ETB flag", last_etx, VECS[vi].fin);
    end

    // R8 corrupted crc high byte
    build_line(VECS[0]);
    q = exp_line;
    q[q.size()-1] = q[q.size()-1] ^ 8'h01;
    feed_rx(q, 1'b0);
    check_rx_data("R8 corrupted block");
    chk(done_cnt == 1 && last_crc == 1 && last_fmt == 0, "R8 crc error flagged",
        {done_cnt[3:0], last_crc, last_fmt}, 6'b000110);

    // R9 escape followed by plain byte
    q = '{8'h32, 8'h32, 8'h10, 8'h02, 8'h41, 8'h10, 8'h41};
    feed_rx(q, 1'b0);
    chk(done_cnt == 1 && last_fmt == 1 && last_crc == 0, "R9 format error flagged",
        {done_cnt[3:0], last_fmt, last_crc}, 6'b000110);
    chk(rx_got.size() == 1 && rx_got[0] == 9'h041, "R9 byte before violation",
        rx_got.size(), 1);
    build_line(VECS[5]);
    feed_rx(exp_line, 1'b0);
    check_rx_data("R9 recovery");
    chk(done_cnt == 1 && last_fmt == 0 && last_crc == 0, "R9 next block clean",
        {done_cnt[3:0], last_fmt, last_crc}, 6'b000100);

    // R9 bad byte after opening escape
    q = '{8'h32, 8'h32, 8'h10, 8'h55};
    feed_rx(q, 1'b0);
    chk(done_cnt == 1 && last_fmt == 1, "R9 missing STX", {done_cnt[3:0], last_fmt}, 5'b00011);

    // R6 single SYN does not open a block
    build_line(VECS[4]);
    q = exp_line;
    void'(q.pop_front());
    feed_rx(q, 1'b0);
    chk(rx_got.size() == 0, "R6 one SYN gives no data", rx_got.size(), 0);
    chk(done_cnt == 0, "R6 one SYN gives no done", done_cnt, 0);

    // R6 junk then three SYN, text with SYN pair inside
    build_line(VECS[2]);
    q = exp_line;
    q.push_front(8'h32);
    q.push_front(8'h55);
    feed_rx(q, 1'b1);
    check_rx_data("R6 R7 long sync run");
    chk(done_cnt == 1 && last_crc == 0 && last_fmt == 0, "R6 clean after long run",
        {done_cnt[3:0], last_crc, last_fmt}, 6'b000100);

    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule